// File: doc/BRIEF.md
# Password-Guarded Write Protection Controller

This block sits in front of a flash array's program and erase engine and decides whether each request may go ahead. It decodes single-byte command codes that the host writes over a simple synchronous write port. A 64-bit password, sent as two 32-bit halves, opens the low-numbered guarded blocks. A separate per-block protection bit, enforced while the write-protect pin `wp_n` is low, covers every block. The outcome of each command appears in an 8-bit status word. Bit 7 is a ready flag, and the host polls it after each command finishes before it sends the next one.

Before a guarded block can be programmed, the host writes setup code 78h and then the low password half (password bits [31:0]) to word address 0. It then writes 78h again and the high half (bits [63:32]) to word address 1. Once both halves match, the unlocked flag stays set until reset. A granted program or erase produces a one-cycle `op_go` pulse that carries the operation kind and the block index. A refused one sets a protection error, and no pulse is issued. The parameter `PW_ENABLE` builds a variant without the password feature.

The controller is one state machine with these states:
- `ST_IDLE` waits for a command code.
- `ST_PW_DATA` waits for a password half.
- `ST_NEWPW_DATA` waits for a replacement half.
- `ST_PROG_DATA` waits for the program block address.
- `ST_ERASE_CONF` waits for the erase confirm.
- `ST_PROT_CONF` waits for the protection-bit confirm.
- `ST_BUSY` holds for `BUSY_CYCLES` cycles.

Its transitions are as follows:
- From `ST_IDLE`, codes 78h, 3Ch, 48h, 20h and 60h move to the matching wait state. Codes 50h and unknown codes stay in `ST_IDLE`.
- Every wait state moves to `ST_BUSY` on its next write.
- `ST_BUSY` returns to `ST_IDLE` when its counter reaches zero.

Top module: `pwlock_guard`

## Requirements
- R1: After reset the status word reads 80h: ready set and no flags. Every per-block protection bit is set, the device is locked, and the password equals `RESET_PW`.
- R2: The sequence 78h, low half at address 0, 78h, high half at address 1 sets status bit 0 (unlocked) when both halves match. The bit stays set until reset.
- R3: A mismatching half sets status bit 4 (password error) and does not unlock. A mismatched low half prevents unlocking even if the high half that follows matches.
- R4: A password half written to an address other than the expected one (0 for the low half, 1 for the high half) sets status bit 3 (sequence error). The half tracker then restarts at the low half.
- R5: The last write of every multi-write command drops status bit 7 for `BUSY_CYCLES` cycles. Writes that arrive while bit 7 is low are ignored.
- R6: Code 48h followed by a write whose upper `BLK_W` address bits name a block grants a program when that block is allowed. The grant is `op_go` high for exactly one cycle with `op_erase`=0 and `op_blk` set to the block.
- R7: A program or erase to a guarded block (index below `GUARD_BLOCKS`) while locked is refused. It sets status bit 1 (protection error) and produces no `op_go`.
- R8: While `wp_n` is low, a block whose protection bit is set is refused in the same way as R7. While `wp_n` is high, the protection bits are ignored.
- R9: Code 60h followed by a write to a block address with data D0h clears that block's protection bit, and with data 01h sets it. Any other confirm sets status bit 3.
- R10: Code 20h followed by a write of D0h to a block address grants an erase (`op_go` with `op_erase`=1) under the R7/R8 rules. Any other confirm sets status bit 3 and grants nothing.
- R11: Code 3Ch followed by a write to address 0 or 1 replaces that password half, but only while unlocked. When locked, it sets status bit 1 and leaves the password unchanged.
- R12: Code 50h clears status bits 4, 3 and 1 but keeps bit 0. An unknown code written while idle sets status bit 3.
- R13: With `PW_ENABLE`=0, guarded blocks need no unlock, and code 78h sets status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data; command code in bits [7:0] |
| wp_n | input | 1 | Write-protect pin; low enforces protection bits |
| status | output | 8 | Bit 7 ready, bit 4 password error, bit 3 sequence error, bit 1 protection error, bit 0 unlocked |
| op_go | output | 1 | One-cycle grant of a program or erase |
| op_erase | output | 1 | Grant kind: 1 erase, 0 program |
| op_blk | output | BLK_W | Block index of the grant |

## Verification
The bound checker watches several properties on every cycle:
- Status flags never move while ready is low.
- The unlocked flag never falls.
- Each grant lasts one cycle and lands in busy.
- No grant reaches a guarded block while locked.
- No grant reaches a pin-protected block.

Only the directed scenarios can show which command sequences lead to which result: wrong halves, wrong addresses, refused versus granted blocks, protection-bit updates, password replacement and the variant without the password. Those outcomes depend on the exact order of writes and on the stored password value.

// File: rtl/pwlock_pkg.sv
package pwlock_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PW_DATA,
        ST_NEWPW_DATA,
        ST_PROG_DATA,
        ST_ERASE_CONF,
        ST_PROT_CONF,
        ST_BUSY
    } lock_state_e;

    localparam logic [7:0] CMD_PW_SETUP  = 8'h78;
    localparam logic [7:0] CMD_PW_NEW    = 8'h3C;
    localparam logic [7:0] CMD_PROG      = 8'h48;
    localparam logic [7:0] CMD_ERASE     = 8'h20;
    localparam logic [7:0] CMD_PROT      = 8'h60;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
    localparam logic [7:0] CONF_GO       = 8'hD0;
    localparam logic [7:0] CONF_SET_PROT = 8'h01;

    localparam int unsigned STAT_READY    = 7;
    localparam int unsigned STAT_PW_ERR   = 4;
    localparam int unsigned STAT_SEQ_ERR  = 3;
    localparam int unsigned STAT_PROT_ERR = 1;
    localparam int unsigned STAT_UNLOCKED = 0;

endpackage

// File: rtl/pwlock_store.sv
module pwlock_store #(
    parameter int unsigned       HALF_W   = 32,
    parameter logic [2*HALF_W-1:0] RESET_PW = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              load_half,
    input  logic              cmp_half,
    input  logic [HALF_W-1:0] data_in,
    output logic              half_match
);
    localparam int unsigned NUM_HALVES = 2;

    logic [HALF_W-1:0] half_q [NUM_HALVES];

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q[h] <= RESET_PW[h*HALF_W +: HALF_W];
            end else if (load_en && (load_half == h[0])) begin
                half_q[h] <= data_in;
            end
        end
    end

    always_comb begin
        half_match = (data_in == half_q[cmp_half]);
    end

endmodule

// File: rtl/pwlock_prot_bank.sv
module pwlock_prot_bank #(
    parameter int unsigned BLK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [BLK_W-1:0] upd_blk,
    input  logic             upd_val,
    output logic [(1<<BLK_W)-1:0] prot_vec
);
    localparam int unsigned NUM_BLK = 1 << BLK_W;

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prot_vec[b] <= 1'b1;
            end else if (upd_en && (upd_blk == BLK_W'(b))) begin
                prot_vec[b] <= upd_val;
            end
        end
    end

endmodule

// File: rtl/pwlock_fsm.sv
module pwlock_fsm
    import pwlock_pkg::*;
#(
    parameter int unsigned ADDR_W       = 20,
    parameter int unsigned BLK_W        = 3,
    parameter int unsigned GUARD_BLOCKS = 2,
    parameter int unsigned BUSY_CYCLES  = 4,
    parameter bit          PW_ENABLE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              wp_n,
    input  logic [(1<<BLK_W)-1:0] prot_vec,
    input  logic              half_match,
    output logic              cmp_half,
    output logic              pw_load_en,
    output logic              pw_load_half,
    output logic              prot_upd_en,
    output logic [BLK_W-1:0]  prot_upd_blk,
    output logic              prot_upd_val,
    output logic [7:0]        status,
    output logic              op_go,
    output logic              op_erase,
    output logic [BLK_W-1:0]  op_blk
);
    localparam int unsigned CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    lock_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic half_q, half_d;
    logic lo_ok_q, lo_ok_d;
    logic unl_q, unl_d;
    logic pw_err_q, pw_err_d;
    logic seq_err_q, seq_err_d;
    logic prot_err_q, prot_err_d;
    logic go_q, go_d;
    logic erase_q, erase_d;
    logic [BLK_W-1:0] blk_q, blk_d;

    logic [7:0]       code;
    logic [BLK_W-1:0] wr_blk;
    logic             guarded;
    logic             denied;
    logic             addr_is_half;
    logic             addr_is_pair;

    always_comb begin
        code         = wr_data[7:0];
        wr_blk       = wr_addr[ADDR_W-1 -: BLK_W];
        guarded      = (int'(wr_blk) < int'(GUARD_BLOCKS));
        denied       = (PW_ENABLE && guarded && !unl_q) || (!wp_n && prot_vec[wr_blk]);
        addr_is_half = (wr_addr == {{(ADDR_W-1){1'b0}}, half_q});
        addr_is_pair = (wr_addr[ADDR_W-1:1] == '0);
        cmp_half     = half_q;
    end

    // State register and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            half_q     <= 1'b0;
            lo_ok_q    <= 1'b0;
            unl_q      <= 1'b0;
            pw_err_q   <= 1'b0;
            seq_err_q  <= 1'b0;
            prot_err_q <= 1'b0;
            go_q       <= 1'b0;
            erase_q    <= 1'b0;
            blk_q      <= '0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            half_q     <= half_d;
            lo_ok_q    <= lo_ok_d;
            unl_q      <= unl_d;
            pw_err_q   <= pw_err_d;
            seq_err_q  <= seq_err_d;
            prot_err_q <= prot_err_d;
            go_q       <= go_d;
            erase_q    <= erase_d;
            blk_q      <= blk_d;
        end
    end

    // Next state and per-write decisions
    always_comb begin
        state_d      = state_q;
        cnt_d        = cnt_q;
        half_d       = half_q;
        lo_ok_d      = lo_ok_q;
        unl_d        = unl_q;
        pw_err_d     = pw_err_q;
        seq_err_d    = seq_err_q;
        prot_err_d   = prot_err_q;
        go_d         = 1'b0;
        erase_d      = erase_q;
        blk_d        = blk_q;
        pw_load_en   = 1'b0;
        pw_load_half = wr_addr[0];
        prot_upd_en  = 1'b0;
        prot_upd_blk = wr_blk;
        prot_upd_val = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (wr_en) begin
                    case (code)
                        CMD_PW_SETUP: begin
                            if (PW_ENABLE) state_d = ST_PW_DATA;
                            else           seq_err_d = 1'b1;
                        end
                        CMD_PW_NEW: begin
                            if (PW_ENABLE) state_d = ST_NEWPW_DATA;
                            else           seq_err_d = 1'b1;
                        end
                        CMD_PROG:  state_d = ST_PROG_DATA;
                        CMD_ERASE: state_d = ST_ERASE_CONF;
                        CMD_PROT:  state_d = ST_PROT_CONF;
                        CMD_CLR_STAT: begin
                            pw_err_d   = 1'b0;
                            seq_err_d  = 1'b0;
                            prot_err_d = 1'b0;
                        end
                        default: seq_err_d = 1'b1;
                    endcase
                end
            end

            ST_PW_DATA: begin
                if (wr_en) begin
                    state_d = ST_BUSY;
                    cnt_d   = CNT_LOAD;
                    if (!addr_is_half) begin
                        seq_err_d = 1'b1;
                        half_d    = 1'b0;
                        lo_ok_d   = 1'b0;
                    end else if (!half_q) begin
                        half_d  = 1'b1;
                        lo_ok_d = half_match;
                        if (!half_match) pw_err_d = 1'b1;
                    end else begin
                        half_d  = 1'b0;
                        lo_ok_d = 1'b0;
                        if (lo_ok_q && half_match) unl_d = 1'b1;
                        else                       pw_err_d = 1'b1;
                    end
                end
            end

            ST_NEWPW_DATA: begin
                if (wr_en) begin
                    state_d = ST_BUSY;
                    cnt_d   = CNT_LOAD;
                    if (!addr_is_pair)  seq_err_d  = 1'b1;
                    else if (!unl_q)    prot_err_d = 1'b1;
                    else                pw_load_en = 1'b1;
                end
            end

            ST_PROG_DATA: begin
                if (wr_en) begin
                    state_d = ST_BUSY;
                    cnt_d   = CNT_LOAD;
                    if (denied) begin
                        prot_err_d = 1'b1;
                    end else begin
                        go_d    = 1'b1;
                        erase_d = 1'b0;
                        blk_d   = wr_blk;
                    end
                end
            end

            ST_ERASE_CONF: begin
                if (wr_en) begin
                    state_d = ST_BUSY;
                    cnt_d   = CNT_LOAD;
                    if (code != CONF_GO) begin
                        seq_err_d = 1'b1;
                    end else if (denied) begin
                        prot_err_d = 1'b1;
                    end else begin
                        go_d    = 1'b1;
                        erase_d = 1'b1;
                        blk_d   = wr_blk;
                    end
                end
            end

            ST_PROT_CONF: begin
                if (wr_en) begin
                    state_d = ST_BUSY;
                    cnt_d   = CNT_LOAD;
                    if (code == CONF_GO) begin
                        prot_upd_en  = 1'b1;
                        prot_upd_val = 1'b0;
                    end else if (code == CONF_SET_PROT) begin
                        prot_upd_en  = 1'b1;
                        prot_upd_val = 1'b1;
                    end else begin
                        seq_err_d = 1'b1;
                    end
                end
            end

            ST_BUSY: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
        endcase
    end

    // Outputs
    always_comb begin
        status = '0;
        status[STAT_READY]    = (state_q != ST_BUSY);
        status[STAT_PW_ERR]   = pw_err_q;
        status[STAT_SEQ_ERR]  = seq_err_q;
        status[STAT_PROT_ERR] = prot_err_q;
        status[STAT_UNLOCKED] = unl_q;
        op_go    = go_q;
        op_erase = erase_q;
        op_blk   = blk_q;
    end

endmodule

// File: rtl/pwlock_guard.sv
module pwlock_guard #(
    parameter int unsigned  ADDR_W       = 20,
    parameter int unsigned  BLK_W        = 3,
    parameter int unsigned  GUARD_BLOCKS = 2,
    parameter int unsigned  BUSY_CYCLES  = 4,
    parameter bit           PW_ENABLE    = 1'b1,
    parameter logic [63:0]  RESET_PW     = 64'h0123_4567_89AB_CDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              wp_n,
    output logic [7:0]        status,
    output logic              op_go,
    output logic              op_erase,
    output logic [BLK_W-1:0]  op_blk
);
    localparam int unsigned HALF_W  = 32;
    localparam int unsigned NUM_BLK = 1 << BLK_W;

    logic               half_match;
    logic               cmp_half;
    logic               pw_load_en;
    logic               pw_load_half;
    logic               prot_upd_en;
    logic [BLK_W-1:0]   prot_upd_blk;
    logic               prot_upd_val;
    logic [NUM_BLK-1:0] prot_vec;

    pwlock_store #(
        .HALF_W   (HALF_W),
        .RESET_PW (RESET_PW)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (pw_load_en),
        .load_half  (pw_load_half),
        .cmp_half   (cmp_half),
        .data_in    (wr_data),
        .half_match (half_match)
    );

    pwlock_prot_bank #(
        .BLK_W (BLK_W)
    ) u_prot (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (prot_upd_en),
        .upd_blk  (prot_upd_blk),
        .upd_val  (prot_upd_val),
        .prot_vec (prot_vec)
    );

    pwlock_fsm #(
        .ADDR_W       (ADDR_W),
        .BLK_W        (BLK_W),
        .GUARD_BLOCKS (GUARD_BLOCKS),
        .BUSY_CYCLES  (BUSY_CYCLES),
        .PW_ENABLE    (PW_ENABLE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wp_n         (wp_n),
        .prot_vec     (prot_vec),
        .half_match   (half_match),
        .cmp_half     (cmp_half),
        .pw_load_en   (pw_load_en),
        .pw_load_half (pw_load_half),
        .prot_upd_en  (prot_upd_en),
        .prot_upd_blk (prot_upd_blk),
        .prot_upd_val (prot_upd_val),
        .status       (status),
        .op_go        (op_go),
        .op_erase     (op_erase),
        .op_blk       (op_blk)
    );

endmodule

// File: rtl/pwlock_guard_chk.sv
module pwlock_guard_chk #(
    parameter int unsigned BLK_W        = 3,
    parameter int unsigned GUARD_BLOCKS = 2,
    parameter bit          PW_ENABLE    = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wp_n,
    input logic [7:0]            status,
    input logic                  op_go,
    input logic [BLK_W-1:0]      op_blk,
    input logic [(1<<BLK_W)-1:0] prot_vec
);
    logic                  wp_q;
    logic [(1<<BLK_W)-1:0] prot_q;
    logic                  ready;
    logic                  unlocked;

    assign ready    = status[7];
    assign unlocked = status[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q   <= 1'b1;
            prot_q <= '1;
        end else begin
            wp_q   <= wp_n;
            prot_q <= prot_vec;
        end
    end

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(status[4:0]));

    // R2
    unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(unlocked));

    // R6
    go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |-> !ready);

    // R6
    go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |=> !op_go);

    // R7
    guard_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && PW_ENABLE && (int'(op_blk) < int'(GUARD_BLOCKS))) |-> unlocked);

    // R8
    wp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && !wp_q) |-> !prot_q[op_blk]);

    // R3
    pw_err_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> !ready);

endmodule

bind pwlock_guard pwlock_guard_chk #(
    .BLK_W        (BLK_W),
    .GUARD_BLOCKS (GUARD_BLOCKS),
    .PW_ENABLE    (PW_ENABLE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .status   (status),
    .op_go    (op_go),
    .op_blk   (op_blk),
    .prot_vec (prot_vec)
);

// File: tb/pwlock_guard_tb.sv
module pwlock_guard_tb;
    localparam int unsigned ADDR_W = 20;
    localparam int unsigned BLK_W  = 3;
    localparam logic [63:0] PW     = 64'h0123_4567_89AB_CDEF;
    localparam logic [31:0] PW_LO  = PW[31:0];
    localparam logic [31:0] PW_HI  = PW[63:32];

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en_a = 1'b0;
    logic              en_b = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       data = '0;
    logic              wp_n = 1'b1;
    logic [7:0]        st_a, st_b;
    logic              go_a, go_b, er_a, er_b;
    logic [BLK_W-1:0]  blk_a, blk_b;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwlock_guard #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .RESET_PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(en_a), .wr_addr(addr), .wr_data(data),
        .wp_n(wp_n), .status(st_a), .op_go(go_a), .op_erase(er_a), .op_blk(blk_a));

    pwlock_guard #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .RESET_PW(PW), .PW_ENABLE(1'b0)) u_nopw (
        .clk(clk), .rst_n(rst_n), .wr_en(en_b), .wr_addr(addr), .wr_data(data),
        .wp_n(wp_n), .status(st_b), .op_go(go_b), .op_erase(er_b), .op_blk(blk_b));

    function automatic logic [ADDR_W-1:0] baddr(input int b);
        return ADDR_W'(b) << (ADDR_W - BLK_W);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit tgt_b, input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; data = d;
        if (tgt_b) en_b = 1'b1; else en_a = 1'b1;
        @(negedge clk);
        en_a = 1'b0; en_b = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 50 && !(st_a[7] && st_b[7]); i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock(input logic [31:0] lo, input logic [31:0] hi);
        wr(0, '0, 32'h78); wr(0, 20'd0, lo); wait_ready();
        wr(0, '0, 32'h78); wr(0, 20'd1, hi); wait_ready();
    endtask

    task automatic t_reset();
        chk("R1 status", st_a, 8'h80);
        chk("R1 op_go", go_a, 0);
    endtask

    task automatic t_locked_prog();
        wp_n = 1'b1;
        wr(0, '0, 32'h48); wr(0, baddr(0), 32'h0);
        chk("R7 no grant", go_a, 0);
        chk("R5 busy", st_a[7], 0);
        wait_ready();
        chk("R7 prot err", st_a, 8'h82);
        wr(0, '0, 32'h50);
        chk("R12 clear", st_a, 8'h80);
    endtask

    task automatic t_bad_half();
        unlock(32'hDEAD_BEEF, PW_HI);
        chk("R3 mismatch stays locked", st_a, 8'h90);
        wr(0, '0, 32'h50);
    endtask

    task automatic t_bad_addr();
        wr(0, '0, 32'h78); wr(0, 20'd1, PW_LO); wait_ready();
        chk("R4 seq err", st_a, 8'h88);
        wr(0, '0, 32'h50);
        wr(0, '0, 32'h78); wr(0, 20'd0, PW_LO); wait_ready();
        chk("R2 half only", st_a, 8'h80);
        wr(0, '0, 32'h78); wr(0, 20'd1, PW_HI); wait_ready();
        chk("R2 unlocked", st_a, 8'h81);
    endtask

    task automatic t_busy_ignore();
        wr(0, '0, 32'h11);
        chk("R12 unknown code", st_a, 8'h89);
        wr(0, '0, 32'h60); wr(0, baddr(7), 32'hD0);
        wr(0, '0, 32'h50);
        wait_ready();
        chk("R5 write in busy ignored", st_a, 8'h89);
        wr(0, '0, 32'h50);
        chk("R12 keeps unlocked", st_a, 8'h81);
    endtask

    task automatic t_prog_ok();
        wp_n = 1'b1;
        wr(0, '0, 32'h48); wr(0, baddr(1) | 20'h123, 32'h0);
        chk("R6 grant", {go_a, er_a, blk_a}, {1'b1, 1'b0, 3'd1});
        @(negedge clk);
        chk("R6 one cycle", go_a, 0);
        wait_ready();
    endtask

    task automatic t_wp();
        wp_n = 1'b0;
        wr(0, '0, 32'h48); wr(0, baddr(5), 32'h0);
        chk("R8 pin refuses", go_a, 0);
        wait_ready();
        chk("R8 prot err", st_a, 8'h83);
        wr(0, '0, 32'h50);
        wr(0, '0, 32'h60); wr(0, baddr(5), 32'hD0); wait_ready();
        wr(0, '0, 32'h48); wr(0, baddr(5), 32'h0);
        chk("R9 cleared bit grants", {go_a, blk_a}, {1'b1, 3'd5});
        wait_ready();
        wr(0, '0, 32'h60); wr(0, baddr(5), 32'h01); wait_ready();
        wr(0, '0, 32'h48); wr(0, baddr(5), 32'h0);
        chk("R9 set bit refuses", go_a, 0);
        wait_ready();
        wr(0, '0, 32'h50);
        wr(0, '0, 32'h60); wr(0, baddr(5), 32'h55); wait_ready();
        chk("R9 bad confirm", st_a, 8'h89);
        wr(0, '0, 32'h50);
        wp_n = 1'b1;
        wr(0, '0, 32'h48); wr(0, baddr(5), 32'h0);
        chk("R8 pin high overrides", go_a, 1);
        wait_ready();
    endtask

    task automatic t_erase();
        wp_n = 1'b1;
        wr(0, '0, 32'h20); wr(0, baddr(3), 32'h33);
        chk("R10 bad confirm no grant", go_a, 0);
        wait_ready();
        chk("R10 seq err", st_a, 8'h89);
        wr(0, '0, 32'h50);
        wr(0, '0, 32'h20); wr(0, baddr(3), 32'hD0);
        chk("R10 erase grant", {go_a, er_a, blk_a}, {1'b1, 1'b1, 3'd3});
        wait_ready();
    endtask

    task automatic t_newpw();
        wr(0, '0, 32'h3C); wr(0, 20'd0, 32'h1111_2222); wait_ready();
        wr(0, '0, 32'h3C); wr(0, 20'd1, 32'h3333_4444); wait_ready();
        unlock(PW_LO, PW_HI);
        chk("R11 old password rejected", st_a, 8'h91);
        wr(0, '0, 32'h50);
        unlock(32'h1111_2222, 32'h3333_4444);
        chk("R11 new password accepted", st_a, 8'h81);
        do_reset();
        chk("R1 reset relocks", st_a, 8'h80);
        wr(0, '0, 32'h3C); wr(0, 20'd0, 32'h0); wait_ready();
        chk("R11 refused when locked", st_a, 8'h82);
        wr(0, '0, 32'h50);
        unlock(PW_LO, PW_HI);
        chk("R1 R11 reset password intact", st_a, 8'h81);
    endtask

    task automatic t_nopw();
        do_reset();
        wp_n = 1'b1;
        wr(1, '0, 32'h48); wr(1, baddr(0), 32'h0);
        chk("R13 no guard", go_b, 1);
        wait_ready();
        wr(1, '0, 32'h78);
        chk("R13 setup rejected", st_b, 8'h88);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_locked_prog();
                t_bad_half();
                t_bad_addr();
                t_busy_ignore();
                t_prog_ok();
                t_wp();
                t_erase();
                t_newpw();
                t_nopw();
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule